// File: doc/BRIEF.md
# Background Multiply Unit with HI/LO Result Registers

This unit serves a 32-bit processor core that keeps multiply results in two dedicated registers: HI for the upper word and LO for the lower word. The core hands it a decoded command made of a six-bit function code and two operands. A multiply command starts a shift-and-add sequence that consumes one multiplier bit per clock, so the product is ready XLEN cycles after the command is accepted. While that sequence runs, commands that do not touch HI or LO are still accepted, so the rest of the pipeline keeps moving.

Reads of HI or LO return data on `rd_data` in the cycle they are accepted. A read that arrives while a multiply is running is held off by `cmd_ready` until the product has been written. A write to HI or LO, or a second multiply, is held off in the same way. A held write therefore lands after the product and replaces its half. Multiplication never raises an overflow or any other exception. The operand width is a parameter, and the default is 32.

Top module: `mdu_top`

## Requirements
- R1: After reset, `hi_out` and `lo_out` are zero, `busy` is low and `cmd_ready` is high.
- R2: Function code 6'b011001 multiplies `cmd_a` by `cmd_b` as unsigned numbers. The low XLEN bits of the 2*XLEN-bit product go to LO and the high XLEN bits go to HI, at the XLEN-th rising edge after acceptance. `busy` is high for exactly XLEN cycles.
- R3: Function code 6'b011000 does the same with both operands treated as two's-complement. This includes the most negative operand value.
- R4: Function code 6'b010000 reads HI and 6'b010010 reads LO. When no multiply is running, the read is accepted at once, with `rd_valid` high and `rd_data` holding the register in the same cycle.
- R5: A read issued while `busy` is high sees `cmd_ready` and `rd_valid` low until the multiply completes. It then returns the new product half.
- R6: Function code 6'b010001 loads `cmd_a` into HI and 6'b010011 loads `cmd_a` into LO, at the accepting edge. The other register is left untouched.
- R7: A HI/LO write issued while `busy` is high is stalled and is not lost. It takes effect after the product is written and replaces that half.
- R8: A multiply issued while `busy` is high is stalled until the running one completes. It then runs normally.
- R9: Any other function code is accepted at once, even while busy. It leaves HI and LO unchanged, never raises `rd_valid`, and does not disturb a running multiply.
- R10: While a multiply is running, `hi_out` and `lo_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A decoded command is presented |
| cmd_func | input | 6 | Function code of the command |
| cmd_a | input | XLEN | First operand, also the data for HI/LO writes |
| cmd_b | input | XLEN | Second operand |
| cmd_ready | output | 1 | Command accepted this cycle (low means stall) |
| rd_valid | output | 1 | An accepted HI/LO read is returning data |
| rd_data | output | XLEN | Read data, zero when `rd_valid` is low |
| busy | output | 1 | A multiply is in progress |
| hi_out | output | XLEN | Current HI contents |
| lo_out | output | XLEN | Current LO contents |

## Verification
The bench runs at a width of four bits and sweeps every operand pair in both signed and unsigned mode. The sweep catches sign-correction slips: a wrong magnitude for the most negative value, or a negation applied when only one product half needs it. Each sweep read is issued right behind its multiply, so a stall count off by one cycle, or a read that slips through early and returns the old HI/LO, shows up at once. Directed sequences cover three more faults. A write issued during a multiply could be dropped or overwritten by the product. A second multiply could corrupt the first. An unrelated function code could be stalled or could leak into the registers.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   localparam int FUNC_W = 6;

   localparam logic [FUNC_W-1:0] FN_MUL_S = 6'b011000;
   localparam logic [FUNC_W-1:0] FN_MUL_U = 6'b011001;
   localparam logic [FUNC_W-1:0] FN_RD_HI = 6'b010000;
   localparam logic [FUNC_W-1:0] FN_WR_HI = 6'b010001;
   localparam logic [FUNC_W-1:0] FN_RD_LO = 6'b010010;
   localparam logic [FUNC_W-1:0] FN_WR_LO = 6'b010011;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_MUL_S,
      OP_MUL_U,
      OP_RD_HI,
      OP_RD_LO,
      OP_WR_HI,
      OP_WR_LO
   } mdu_op_e;

   typedef struct packed {
      logic is_mul;
      logic is_signed;
      logic is_rd;
      logic is_wr;
      logic sel_hi;
   } mdu_dec_t;

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
   import mdu_pkg::*;
(
   input  logic [FUNC_W-1:0] func,
   output mdu_op_e           op,
   output mdu_dec_t          dec
);

   always_comb begin
      unique case (func)
         FN_MUL_S: op = OP_MUL_S;
         FN_MUL_U: op = OP_MUL_U;
         FN_RD_HI: op = OP_RD_HI;
         FN_RD_LO: op = OP_RD_LO;
         FN_WR_HI: op = OP_WR_HI;
         FN_WR_LO: op = OP_WR_LO;
         default:  op = OP_NONE;
      endcase
   end

   always_comb begin
      dec           = '0;
      dec.is_mul    = (op == OP_MUL_S) || (op == OP_MUL_U);
      dec.is_signed = (op == OP_MUL_S);
      dec.is_rd     = (op == OP_RD_HI) || (op == OP_RD_LO);
      dec.is_wr     = (op == OP_WR_HI) || (op == OP_WR_LO);
      dec.sel_hi    = (op == OP_RD_HI) || (op == OP_WR_HI);
   end

endmodule

// File: rtl/mdu_shift_mult.sv
module mdu_shift_mult #(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_signed,
   input  logic [XLEN-1:0]   op_a,
   input  logic [XLEN-1:0]   op_b,
   output logic              busy,
   output logic              done,
   output logic [2*XLEN-1:0] prod
);

   localparam int PW    = 2 * XLEN;
   localparam int CNT_W = (XLEN > 2) ? $clog2(XLEN) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(XLEN - 1);

   logic [XLEN-1:0] raw [2];
   logic [XLEN-1:0] mag [2];
   logic [1:0]      negv;

   assign raw[0] = op_a;
   assign raw[1] = op_b;

   // operand conditioning: magnitude and sign of each operand
   for (genvar g = 0; g < 2; g++) begin : g_opnd
      assign negv[g] = is_signed & raw[g][XLEN-1];
      assign mag[g]  = negv[g] ? (~raw[g] + 1'b1) : raw[g];
   end

   logic [XLEN-1:0]  mcand_q;
   logic [PW-1:0]    p_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             neg_q;

   logic [XLEN-1:0] addend;
   logic [XLEN:0]   sum;
   logic [PW-1:0]   p_nxt;
   logic            last;

   assign addend = p_q[0] ? mcand_q : '0;
   assign sum    = {1'b0, p_q[PW-1:XLEN]} + {1'b0, addend};
   assign p_nxt  = {sum, p_q[XLEN-1:1]};
   assign last   = busy_q && (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         p_q     <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         neg_q   <= 1'b0;
      end else if (start && !busy_q) begin
         mcand_q <= mag[0];
         p_q     <= {{XLEN{1'b0}}, mag[1]};
         cnt_q   <= '0;
         busy_q  <= 1'b1;
         neg_q   <= negv[0] ^ negv[1];
      end else if (busy_q) begin
         p_q   <= p_nxt;
         cnt_q <= cnt_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign done = last;
   assign prod = neg_q ? (~p_nxt + 1'b1) : p_nxt;

endmodule

// File: rtl/mdu_hilo_regs.sv
module mdu_hilo_regs #(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_we,
   input  logic [2*XLEN-1:0] prod,
   input  logic [1:0]        wr_en,
   input  logic [XLEN-1:0]   wr_data,
   output logic [XLEN-1:0]   lo,
   output logic [XLEN-1:0]   hi
);

   logic [XLEN-1:0] q [2];

   // index 0 is LO (low product half), index 1 is HI
   for (genvar g = 0; g < 2; g++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q[g] <= '0;
         else if (prod_we)   q[g] <= prod[g*XLEN +: XLEN];
         else if (wr_en[g])  q[g] <= wr_data;
      end
   end

   assign lo = q[0];
   assign hi = q[1];

endmodule

// File: rtl/mdu_top.sv
module mdu_top
   import mdu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [5:0]        cmd_func,
   input  logic [XLEN-1:0]   cmd_a,
   input  logic [XLEN-1:0]   cmd_b,
   output logic              cmd_ready,
   output logic              rd_valid,
   output logic [XLEN-1:0]   rd_data,
   output logic              busy,
   output logic [XLEN-1:0]   hi_out,
   output logic [XLEN-1:0]   lo_out
);

   if (XLEN < 2) begin : g_bad_xlen
      $error("mdu_top: XLEN must be at least 2");
   end
   if (FUNC_W != 6) begin : g_bad_func
      $error("mdu_top: function code width must be 6");
   end

   mdu_op_e  op;
   mdu_dec_t dec;

   mdu_decode u_dec (
      .func (cmd_func),
      .op   (op),
      .dec  (dec)
   );

   logic              m_busy;
   logic              m_done;
   logic [2*XLEN-1:0] m_prod;
   logic              touches_hilo;
   logic              accept;
   logic              start;
   logic [1:0]        wr_en;

   assign touches_hilo = dec.is_mul | dec.is_rd | dec.is_wr;
   assign cmd_ready    = !(touches_hilo && m_busy);
   assign accept       = cmd_valid && cmd_ready;
   assign start        = accept && dec.is_mul;
   assign wr_en[1]     = accept && dec.is_wr && dec.sel_hi;
   assign wr_en[0]     = accept && dec.is_wr && !dec.sel_hi;

   mdu_shift_mult #(.XLEN(XLEN)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_signed (dec.is_signed),
      .op_a      (cmd_a),
      .op_b      (cmd_b),
      .busy      (m_busy),
      .done      (m_done),
      .prod      (m_prod)
   );

   mdu_hilo_regs #(.XLEN(XLEN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .prod_we (m_done),
      .prod    (m_prod),
      .wr_en   (wr_en),
      .wr_data (cmd_a),
      .lo      (lo_out),
      .hi      (hi_out)
   );

   assign rd_valid = accept && dec.is_rd;
   assign rd_data  = !rd_valid  ? '0 :
                     dec.sel_hi ? hi_out : lo_out;
   assign busy     = m_busy;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [5:0]      cmd_func,
   input logic [XLEN-1:0] cmd_a,
   input logic            cmd_ready,
   input logic            rd_valid,
   input logic            busy,
   input logic [XLEN-1:0] hi_out,
   input logic [XLEN-1:0] lo_out
);

   logic c_mul, c_rd, c_wr_hi, c_wr_lo;
   assign c_mul   = (cmd_func == 6'b011000) || (cmd_func == 6'b011001);
   assign c_rd    = (cmd_func == 6'b010000) || (cmd_func == 6'b010010);
   assign c_wr_hi = (cmd_func == 6'b010001);
   assign c_wr_lo = (cmd_func == 6'b010011);

   int unsigned busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R2: busy never outlasts XLEN cycles
   assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < XLEN));

   // R2: busy lasts exactly XLEN cycles
   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(busy_run) == XLEN - 1));

   assert_mul_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && c_mul) |=> busy);

   assert_read_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && c_rd) |-> (!cmd_ready && !rd_valid));

   assert_write_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && c_wr_hi) |=> (hi_out == $past(cmd_a)));

   assert_write_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && c_wr_lo) |=> (lo_out == $past(cmd_a)));

   assert_write_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && (c_wr_hi || c_wr_lo)) |-> !cmd_ready);

   assert_mul_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && c_mul) |-> !cmd_ready);

   assert_other_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !c_mul && !c_rd && !c_wr_hi && !c_wr_lo) |-> (cmd_ready && !rd_valid));

   assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(hi_out) && $stable(lo_out)));

endmodule

bind mdu_top mdu_checker #(.XLEN(XLEN)) u_mdu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_func  (cmd_func),
   .cmd_a     (cmd_a),
   .cmd_ready (cmd_ready),
   .rd_valid  (rd_valid),
   .busy      (busy),
   .hi_out    (hi_out),
   .lo_out    (lo_out)
);

// File: tb/tb_mdu_top.sv
module tb_mdu_top;

   localparam int W = 4;
   localparam logic [5:0] F_MS  = 6'b011000;
   localparam logic [5:0] F_MU  = 6'b011001;
   localparam logic [5:0] F_RHI = 6'b010000;
   localparam logic [5:0] F_RLO = 6'b010010;
   localparam logic [5:0] F_WHI = 6'b010001;
   localparam logic [5:0] F_WLO = 6'b010011;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [5:0]   cmd_func = '0;
   logic [W-1:0] cmd_a = '0;
   logic [W-1:0] cmd_b = '0;
   logic         cmd_ready, rd_valid, busy;
   logic [W-1:0] rd_data, hi_out, lo_out;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   mdu_top #(.XLEN(W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_func  (cmd_func),
      .cmd_a     (cmd_a),
      .cmd_b     (cmd_b),
      .cmd_ready (cmd_ready),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .busy      (busy),
      .hi_out    (hi_out),
      .lo_out    (lo_out)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // present a command, wait out any stall, return stall count and read result
   task automatic send(input logic [5:0] f, input int a, input int b,
                       output int stalls, output int rdat, output int rv);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_func  = f;
      cmd_a     = W'(a);
      cmd_b     = W'(b);
      #1;
      stalls = 0;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      rv   = int'(rd_valid);
      rdat = int'(rd_data);
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
   endtask

   function automatic int sx(input int v);
      return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int st, rd, rv, exp, mask;
      mask = (1 << W) - 1;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "hi after reset", int'(hi_out), 0);
      chk("R1", "lo after reset", int'(lo_out), 0);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "ready after reset", int'(cmd_ready), 1);
      rst_n = 1'b1;

      // R6 / R4: direct writes and idle reads
      send(F_WHI, 10, 0, st, rd, rv);
      chk("R6", "hi after write", int'(hi_out), 10);
      chk("R6", "lo untouched by hi write", int'(lo_out), 0);
      send(F_WLO, 5, 0, st, rd, rv);
      chk("R6", "lo after write", int'(lo_out), 5);
      chk("R6", "hi untouched by lo write", int'(hi_out), 10);
      send(F_RHI, 0, 0, st, rd, rv);
      chk("R4", "hi read stalls", st, 0);
      chk("R4", "hi read valid", rv, 1);
      chk("R4", "hi read data", rd, 10);
      send(F_RLO, 0, 0, st, rd, rv);
      chk("R4", "lo read data", rd, 5);

      // R2 / R3 / R5: full sweep of both modes
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            for (int s = 0; s < 2; s++) begin
               exp = (s != 0) ? ((sx(a) * sx(b)) & ((1 << (2 * W)) - 1)) : a * b;
               send((s != 0) ? F_MS : F_MU, a, b, st, rd, rv);
               send(F_RLO, 0, 0, st, rd, rv);
               chk("R5", "read stall cycles behind multiply", st, W);
               chk((s != 0) ? "R3" : "R2", "product low word", rd, exp & mask);
               send(F_RHI, 0, 0, st, rd, rv);
               chk((s != 0) ? "R3" : "R2", "product high word", rd, (exp >> W) & mask);
            end
         end
      end

      // R7: write during multiply lands after the product
      send(F_WHI, 10, 0, st, rd, rv);
      send(F_MU, 3, 5, st, rd, rv);
      send(F_WLO, 9, 0, st, rd, rv);
      chk("R7", "write stall cycles", st, W);
      send(F_RLO, 0, 0, st, rd, rv);
      chk("R7", "lo holds late write", rd, 9);
      send(F_RHI, 0, 0, st, rd, rv);
      chk("R7", "hi holds product half", rd, 0);

      // R8: second multiply waits for the first
      send(F_MU, 15, 15, st, rd, rv);
      send(F_MS, 15, 15, st, rd, rv);
      chk("R8", "multiply stall cycles", st, W);
      send(F_RLO, 0, 0, st, rd, rv);
      chk("R8", "second product low", rd, 1);
      send(F_RHI, 0, 0, st, rd, rv);
      chk("R8", "second product high", rd, 0);

      // R9: unrelated code during and outside a multiply
      send(F_MU, 7, 6, st, rd, rv);
      send(6'b100000, 15, 15, st, rd, rv);
      chk("R9", "other code stall while busy", st, 0);
      chk("R9", "other code no read", rv, 0);
      send(F_RLO, 0, 0, st, rd, rv);
      chk("R9", "product low undisturbed", rd, 10);
      send(F_RHI, 0, 0, st, rd, rv);
      chk("R9", "product high undisturbed", rd, 2);
      send(F_WLO, 3, 0, st, rd, rv);
      send(6'b100001, 15, 15, st, rd, rv);
      @(negedge clk);
      chk("R9", "lo after other code", int'(lo_out), 3);
      chk("R9", "hi after other code", int'(hi_out), 2);
      chk("R9", "busy after other code", int'(busy), 0);

      // R10: registers hold their old values while busy
      send(F_WHI, 5, 0, st, rd, rv);
      send(F_WLO, 6, 0, st, rd, rv);
      send(F_MU, 15, 15, st, rd, rv);
      @(negedge clk);
      chk("R10", "busy early", int'(busy), 1);
      chk("R10", "hi held early", int'(hi_out), 5);
      chk("R10", "lo held early", int'(lo_out), 6);
      repeat (W - 2) @(negedge clk);
      chk("R10", "busy late", int'(busy), 1);
      chk("R10", "hi held late", int'(hi_out), 5);
      chk("R10", "lo held late", int'(lo_out), 6);
      send(F_RHI, 0, 0, st, rd, rv);
      chk("R2", "hi after held multiply", rd, 14);
      send(F_RLO, 0, 0, st, rd, rv);
      chk("R2", "lo after held multiply", rd, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule